// File: doc/BRIEF.md
# User Bit Ping-Pong Capture

This block collects the user bit carried by every received audio subframe into one of two equal buffers. While one buffer fills, the other holds the last completed fill, and the host reads it one byte at a time. When a fill completes, the buffers swap roles. Each completion raises a ready flag and pulses an interrupt. If the host has not acknowledged the previous completion, an overrun flag is also raised.

Capture runs only in the ping-pong mode (`cfg_mode` = 01). The first fill after the block is enabled, or after any change of mode, length or layout, starts at the next block-start (Z preamble) subframe. Later fills follow on at once, with no subframe lost. With the default lengths of 384 and 768 bits, every fill covers whole blocks, so each fill also begins at a block start.

The bits of a fill can be stored in arrival order, or split so that channel A bits fill the lower half and channel B bits the upper half. In a DAT-filter mode the interrupt is raised only when the fill's first bit (the ID bit) differs from that of the previous fill. This applies only when the category code supplied by the channel-status logic equals the DAT code. The ready flag is still raised on every fill.

The controller has three states:
- `ST_IDLE`: the mode is not 01.
- `ST_WAIT_Z`: waiting for the block start.
- `ST_FILL`: filling.

Its transitions are:
- any state to `ST_IDLE` whenever the mode is not 01;
- any state to `ST_WAIT_Z` on a configuration change with the mode at 01;
- `ST_IDLE` to `ST_WAIT_Z` when the mode is 01 and nothing else changes;
- `ST_WAIT_Z` to `ST_FILL` on an accepted block-start subframe.

`ST_FILL` stays in `ST_FILL` across completions.

Top module: `ubit_pingpong`

## Requirements
- R1: After reset, `buf_ready`, `overrun` and `irq` are 0, and `rd_buf` is 1 (buffer 0 is the one filling).
- R2: With `cfg_mode` equal to 00, 10 or 11, no subframe is stored, `buf_ready` stays low, `rd_buf` does not change and `irq` never pulses.
- R3: After the mode becomes 01, or after `cfg_mode`, `cfg_long` or `cfg_split` changes, subframes are dropped until one arrives with `sf_blk_start` = 1. That subframe becomes bit 0 of the fill.
- R4: A fill completes on exactly its SHORT_LEN-th accepted subframe when `cfg_long` = 0, and on its LONG_LEN-th when `cfg_long` = 1.
- R5: With `cfg_split` = 0, bit i of the buffer is the user bit of the i-th accepted subframe. Read byte k presents buffer bit 8k+j on `rd_byte[j]`.
- R6: With `cfg_split` = 1 (`sf_chan_b` = 0 means channel A), the n-th A bit is stored at bit n. The n-th B bit is stored at bit len/2+n.
- R7: In the cycle after the completing subframe is sampled, `buf_ready` is 1, `rd_buf` names the buffer just filled and `irq` is 1. The very next subframe is stored as bit 0 of the other buffer.
- R8: `host_ack` clears `buf_ready` and `overrun`. A completion while `buf_ready` is still set and `host_ack` is low sets `overrun`, and the newest fill becomes readable. A completion in the same cycle as `host_ack` leaves `buf_ready` = 1 and `overrun` = 0.
- R9: With `cfg_dat_filt` = 1 and `cat_code` = DAT_CAT, a completion pulses `irq` only if it is the first completion since the last restart, or if its bit 0 differs from bit 0 of the previous completed fill. `buf_ready` is still set.
- R10: With `cfg_dat_filt` = 0, or with `cat_code` different from DAT_CAT, every completion pulses `irq`.
- R11: `irq` is high for exactly one cycle per pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sf_valid | input | 1 | One-cycle strobe per received subframe |
| sf_chan_b | input | 1 | 0 = channel A, 1 = channel B |
| sf_blk_start | input | 1 | Subframe carries the block-start (Z) preamble |
| sf_user | input | 1 | User bit of the subframe |
| cfg_mode | input | 2 | 01 = ping-pong capture; 00, 10 and 11 = off |
| cfg_long | input | 1 | 0 = SHORT_LEN bits per fill, 1 = LONG_LEN bits per fill |
| cfg_split | input | 1 | 1 = A bits in the lower half, B bits in the upper half |
| cfg_dat_filt | input | 1 | Enables the ID-bit interrupt filter |
| cat_code | input | CAT_W | Category code from the channel-status logic |
| host_ack | input | 1 | Host acknowledges the readable buffer |
| rd_addr | input | BYTE_AW | Byte index into the readable buffer |
| rd_byte | output | 8 | Addressed byte of the readable buffer |
| buf_ready | output | 1 | A completed buffer awaits the host |
| rd_buf | output | 1 | Index of the readable buffer |
| overrun | output | 1 | A completion occurred before the acknowledge |
| irq | output | 1 | One-cycle user-bit interrupt |

## Verification
A host acknowledge and a buffer completion can land in the same cycle. The bench provokes this by asserting `host_ack` in the same cycle as the last subframe of a fill, while `buf_ready` is already set from the previous fill. It then expects `buf_ready` to stay 1, `overrun` to stay 0 and the new data to be readable. The other way round is also checked: a completion with no acknowledge must raise `overrun` and expose the newer fill. These checks are repeated for both lengths and both layouts, with the fill bits computed from an arithmetic pattern.

// File: rtl/ubp_pkg.sv
package ubp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT_Z = 2'd1,
        ST_FILL   = 2'd2
    } ubp_state_t;

    localparam logic [1:0] MODE_PINGPONG = 2'b01;
endpackage

// File: rtl/ubp_ctrl.sv
module ubp_ctrl
    import ubp_pkg::*;
#(
    parameter int SHORT_LEN = 384,
    parameter int LONG_LEN  = 768,
    parameter int CNT_W     = $clog2(LONG_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sf_valid,
    input  logic             sf_chan_b,
    input  logic             sf_blk_start,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_long,
    input  logic             cfg_split,
    input  logic             host_ack,
    output logic             wr_en,
    output logic [CNT_W-1:0] wr_addr,
    output logic             wr_buf,
    output logic             fill_first,
    output logic             fill_done,
    output logic             buf_ready,
    output logic             overrun,
    output ubp_state_t       st
);
    localparam int LEN_W = CNT_W + 1;

    ubp_state_t       st_nx;
    logic [3:0]       cfg_q;
    logic             cfg_chg;
    logic             mode_on;
    logic             accept;
    logic             half_ok;
    logic [LEN_W-1:0] len;
    logic [LEN_W-1:0] half;
    logic [CNT_W-1:0] cnt, a_cnt, b_cnt;

    assign mode_on = (cfg_mode == MODE_PINGPONG);
    assign cfg_chg = ({cfg_mode, cfg_long, cfg_split} != cfg_q);
    assign len     = cfg_long ? LEN_W'(LONG_LEN) : LEN_W'(SHORT_LEN);
    assign half    = len >> 1;

    assign accept = sf_valid && mode_on && !cfg_chg &&
                    ((st == ST_FILL) || (st == ST_WAIT_Z && sf_blk_start));
    assign half_ok = sf_chan_b ? ({1'b0, b_cnt} < half) : ({1'b0, a_cnt} < half);
    assign wr_en      = accept && (!cfg_split || half_ok);
    assign fill_first = accept && (cnt == '0);
    assign fill_done  = accept && ({1'b0, cnt} == len - 1'b1);

    always_comb begin
        if (!cfg_split)
            wr_addr = cnt;
        else if (sf_chan_b)
            wr_addr = CNT_W'(half) + b_cnt;
        else
            wr_addr = a_cnt;
    end

    // next-state logic
    always_comb begin
        st_nx = st;
        if (!mode_on)
            st_nx = ST_IDLE;
        else if (cfg_chg)
            st_nx = ST_WAIT_Z;
        else begin
            unique case (st)
                ST_IDLE:   st_nx = ST_WAIT_Z;
                ST_WAIT_Z: if (accept) st_nx = ST_FILL;
                ST_FILL:   st_nx = ST_FILL;
                default:   st_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= ST_IDLE;
        else
            st <= st_nx;
    end

    // fill counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            a_cnt <= '0;
            b_cnt <= '0;
        end else if (!accept) begin
            if (st != ST_FILL || cfg_chg || !mode_on) begin
                cnt   <= '0;
                a_cnt <= '0;
                b_cnt <= '0;
            end
        end else if (fill_done) begin
            cnt   <= '0;
            a_cnt <= '0;
            b_cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
            if (half_ok) begin
                if (sf_chan_b) b_cnt <= b_cnt + 1'b1;
                else           a_cnt <= a_cnt + 1'b1;
            end
        end
    end

    // outputs: buffer swap, ready, overrun
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            wr_buf    <= 1'b0;
            buf_ready <= 1'b0;
            overrun   <= 1'b0;
        end else begin
            cfg_q <= {cfg_mode, cfg_long, cfg_split};
            if (fill_done)
                wr_buf <= ~wr_buf;
            if (fill_done)
                buf_ready <= 1'b1;
            else if (host_ack)
                buf_ready <= 1'b0;
            if (fill_done && buf_ready && !host_ack)
                overrun <= 1'b1;
            else if (host_ack)
                overrun <= 1'b0;
        end
    end
endmodule

// File: rtl/ubp_store.sv
module ubp_store #(
    parameter int LONG_LEN = 768,
    parameter int CNT_W    = $clog2(LONG_LEN),
    parameter int BYTE_AW  = $clog2(LONG_LEN / 8)
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic               wr_buf,
    input  logic [CNT_W-1:0]   wr_addr,
    input  logic               wr_bit,
    input  logic               rd_buf,
    input  logic [BYTE_AW-1:0] rd_addr,
    output logic [7:0]         rd_byte
);
    logic [7:0] bank_byte [2];

    for (genvar g = 0; g < 2; g++) begin : g_bank
        logic [LONG_LEN-1:0] bits;

        always_ff @(posedge clk) begin
            if (wr_en && (wr_buf == 1'(g)))
                bits[wr_addr] <= wr_bit;
        end

        assign bank_byte[g] = bits[{rd_addr, 3'b000} +: 8];
    end

    assign rd_byte = rd_buf ? bank_byte[1] : bank_byte[0];
endmodule

// File: rtl/ubp_irq.sv
module ubp_irq
    import ubp_pkg::*;
#(
    parameter int                 CAT_W   = 8,
    parameter logic [CAT_W-1:0]   DAT_CAT = 8'hC0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ubp_state_t       st,
    input  logic             fill_first,
    input  logic             fill_done,
    input  logic             first_bit,
    input  logic             cfg_dat_filt,
    input  logic [CAT_W-1:0] cat_code,
    output logic             irq
);
    logic cur_id, prev_id, prev_ok;
    logic dat_on, fire;

    assign dat_on = cfg_dat_filt && (cat_code == DAT_CAT);
    assign fire   = !dat_on || !prev_ok || (cur_id != prev_id);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_id  <= 1'b0;
            prev_id <= 1'b0;
            prev_ok <= 1'b0;
            irq     <= 1'b0;
        end else begin
            irq <= fill_done && fire;
            if (fill_first)
                cur_id <= first_bit;
            if (fill_done) begin
                prev_id <= cur_id;
                prev_ok <= 1'b1;
            end else if (st != ST_FILL) begin
                prev_ok <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ubit_pingpong.sv
module ubit_pingpong
    import ubp_pkg::*;
#(
    parameter int               SHORT_LEN = 384,
    parameter int               LONG_LEN  = 768,
    parameter int               CAT_W     = 8,
    parameter logic [CAT_W-1:0] DAT_CAT   = 8'hC0,
    localparam int              CNT_W     = $clog2(LONG_LEN),
    localparam int              BYTE_AW   = $clog2(LONG_LEN / 8)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sf_valid,
    input  logic               sf_chan_b,
    input  logic               sf_blk_start,
    input  logic               sf_user,
    input  logic [1:0]         cfg_mode,
    input  logic               cfg_long,
    input  logic               cfg_split,
    input  logic               cfg_dat_filt,
    input  logic [CAT_W-1:0]   cat_code,
    input  logic               host_ack,
    input  logic [BYTE_AW-1:0] rd_addr,
    output logic [7:0]         rd_byte,
    output logic               buf_ready,
    output logic               rd_buf,
    output logic               overrun,
    output logic               irq
);
    ubp_state_t       st;
    logic             wr_en, wr_buf, fill_first, fill_done;
    logic [CNT_W-1:0] wr_addr;

    ubp_ctrl #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sf_valid(sf_valid), .sf_chan_b(sf_chan_b),
        .sf_blk_start(sf_blk_start), .cfg_mode(cfg_mode), .cfg_long(cfg_long),
        .cfg_split(cfg_split), .host_ack(host_ack), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_buf(wr_buf), .fill_first(fill_first), .fill_done(fill_done),
        .buf_ready(buf_ready), .overrun(overrun), .st(st)
    );

    ubp_store #(.LONG_LEN(LONG_LEN), .CNT_W(CNT_W), .BYTE_AW(BYTE_AW)) u_store (
        .clk(clk), .wr_en(wr_en), .wr_buf(wr_buf), .wr_addr(wr_addr),
        .wr_bit(sf_user), .rd_buf(rd_buf), .rd_addr(rd_addr), .rd_byte(rd_byte)
    );

    ubp_irq #(.CAT_W(CAT_W), .DAT_CAT(DAT_CAT)) u_irq (
        .clk(clk), .rst_n(rst_n), .st(st), .fill_first(fill_first),
        .fill_done(fill_done), .first_bit(sf_user), .cfg_dat_filt(cfg_dat_filt),
        .cat_code(cat_code), .irq(irq)
    );

    assign rd_buf = ~wr_buf;
endmodule

// File: rtl/ubp_chk.sv
module ubp_chk
    import ubp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cfg_mode,
    input logic       host_ack,
    input logic       irq,
    input logic       buf_ready,
    input logic       overrun,
    input logic       rd_buf,
    input ubp_state_t st,
    input logic       fill_done
);
    // R11
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R7
    irq_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> buf_ready);

    // R7
    irq_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(fill_done));

    // R7
    swap_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_buf) |-> buf_ready);

    // R8
    ack_clears_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !overrun);

    // R8
    ovr_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> ($past(buf_ready) && buf_ready));

    // R2
    mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode != MODE_PINGPONG) |=> (st == ST_IDLE && !irq));
endmodule

bind ubit_pingpong ubp_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .host_ack(host_ack),
    .irq(irq), .buf_ready(buf_ready), .overrun(overrun), .rd_buf(rd_buf),
    .st(st), .fill_done(fill_done)
);

// File: tb/sim_ubit_pingpong.sv
`timescale 1ns/100ps
module sim_ubit_pingpong;
    localparam int         SL = 8;
    localparam int         LL = 16;
    localparam logic [7:0] DC = 8'hC0;
    localparam int         BW = $clog2(LL / 8);

    logic clk = 1'b0;
    logic rst_n;
    logic sf_valid, sf_chan_b, sf_blk_start, sf_user;
    logic [1:0] cfg_mode;
    logic cfg_long, cfg_split, cfg_dat_filt, host_ack;
    logic [7:0] cat_code;
    logic [BW-1:0] rd_addr;
    logic [7:0] rd_byte;
    logic buf_ready, rd_buf, overrun, irq;

    int n_chk = 0, n_fail = 0, irq_cnt = 0;
    logic exp_rd;
    logic [LL-1:0] expv;

    always #2 clk = ~clk;

    ubit_pingpong #(.SHORT_LEN(SL), .LONG_LEN(LL), .CAT_W(8), .DAT_CAT(DC)) u0 (
        .clk(clk), .rst_n(rst_n), .sf_valid(sf_valid), .sf_chan_b(sf_chan_b),
        .sf_blk_start(sf_blk_start), .sf_user(sf_user), .cfg_mode(cfg_mode),
        .cfg_long(cfg_long), .cfg_split(cfg_split), .cfg_dat_filt(cfg_dat_filt),
        .cat_code(cat_code), .host_ack(host_ack), .rd_addr(rd_addr),
        .rd_byte(rd_byte), .buf_ready(buf_ready), .rd_buf(rd_buf),
        .overrun(overrun), .irq(irq)
    );

    always @(posedge clk) if (irq) irq_cnt++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit pbit(input int seed, input int i);
        return ((i * 5 + seed * 3 + (i >> 1)) % 3) == 0;
    endfunction

    task automatic sub(input bit b, input bit z, input bit u, input bit ack);
        @(negedge clk);
        sf_valid = 1'b1; sf_chan_b = b; sf_blk_start = z; sf_user = u; host_ack = ack;
        @(posedge clk); #1;
        sf_valid = 1'b0; sf_blk_start = 1'b0; host_ack = 1'b0;
    endtask

    task automatic fill(input int len, input bit split, input int seed, input int id,
                        input bit zfirst, input bit ack_last, input bit pre_rdy);
        for (int i = 0; i < len; i++) begin
            bit u;
            int pos;
            u = (i == 0 && id >= 0) ? id[0] : pbit(seed, i);
            pos = split ? (i[0] ? len / 2 + i / 2 : i / 2) : i;
            expv[pos] = u;
            if (i == len - 1)
                chk(buf_ready == pre_rdy, "R4 no early completion", buf_ready, pre_rdy);
            sub(i[0], zfirst && i == 0, u, ack_last && i == len - 1);
            if (i == 0)
                chk(irq == 1'b0, "R11 irq one cycle", irq, 0);
        end
    endtask

    task automatic check_data(input int len, input string req);
        for (int k = 0; k < len / 8; k++) begin
            rd_addr = BW'(k);
            #0.2;
            chk(rd_byte == expv[8*k +: 8], req, rd_byte, expv[8*k +: 8]);
        end
    endtask

    task automatic restart(input bit lg, input bit sp);
        @(negedge clk); cfg_mode = 2'b00;
        @(negedge clk); cfg_mode = 2'b01; cfg_long = lg; cfg_split = sp;
        @(negedge clk);
    endtask

    task automatic do_ack();
        @(negedge clk); host_ack = 1'b1;
        @(posedge clk); #1; host_ack = 1'b0;
    endtask

    task automatic after_fill(input int len, input bit sp, input bit exp_ovr, input string tag);
        exp_rd = ~exp_rd;
        chk(buf_ready == 1'b1, {tag, " R7 ready"}, buf_ready, 1);
        chk(rd_buf == exp_rd, {tag, " R7 rd_buf"}, rd_buf, exp_rd);
        chk(overrun == exp_ovr, {tag, " R8 overrun"}, overrun, exp_ovr);
        check_data(len, sp ? {tag, " R6 split data"} : {tag, " R5 data"});
    endtask

    initial begin
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int base;
        rst_n = 1'b0; sf_valid = 0; sf_chan_b = 0; sf_blk_start = 0; sf_user = 0;
        cfg_mode = 2'b00; cfg_long = 0; cfg_split = 0; cfg_dat_filt = 0;
        cat_code = 8'h00; host_ack = 0; rd_addr = '0;
        repeat (3) @(posedge clk);
        #1;
        chk(buf_ready == 0, "R1 ready", buf_ready, 0);
        chk(overrun == 0, "R1 overrun", overrun, 0);
        chk(irq == 0, "R1 irq", irq, 0);
        chk(rd_buf == 1, "R1 rd_buf", rd_buf, 1);
        rst_n = 1'b1;
        exp_rd = 1'b1;

        // sweep lengths and layouts
        for (int lg = 0; lg < 2; lg++) begin
            for (int sp = 0; sp < 2; sp++) begin
                int len;
                len = lg ? LL : SL;
                restart(lg[0], sp[0]);
                base = irq_cnt;
                // R3: subframes before the block start are dropped
                sub(0, 0, 1, 0); sub(1, 0, 1, 0); sub(0, 0, 0, 0);
                chk(buf_ready == 0, "R3 wait for block start", buf_ready, 0);
                fill(len, sp[0], lg * 2 + sp, -1, 1'b1, 1'b0, 1'b0);
                chk(irq == 1, "R7 irq on completion", irq, 1);
                after_fill(len, sp[0], 1'b0, "fill1");
                // back-to-back, unacknowledged: overrun
                fill(len, sp[0], lg * 2 + sp + 5, -1, 1'b0, 1'b0, 1'b1);
                after_fill(len, sp[0], 1'b1, "fill2 R8 overwrite");
                do_ack();
                chk(buf_ready == 0, "R8 ack clears ready", buf_ready, 0);
                chk(overrun == 0, "R8 ack clears overrun", overrun, 0);
                fill(len, sp[0], lg * 2 + sp + 9, -1, 1'b0, 1'b0, 1'b0);
                after_fill(len, sp[0], 1'b0, "fill3");
                // ack in the same cycle as completion
                fill(len, sp[0], lg * 2 + sp + 13, -1, 1'b0, 1'b1, 1'b1);
                after_fill(len, sp[0], 1'b0, "fill4 R8 ack with completion");
                do_ack();
                chk(irq_cnt - base == 4, "R10 irq per completion", irq_cnt - base, 4);
            end
        end

        // DAT filter
        begin
            int ids [5] = '{0, 0, 1, 1, 0};
            int exq [5] = '{1, 0, 1, 0, 1};
            cfg_dat_filt = 1'b1; cat_code = DC;
            restart(1'b0, 1'b0);
            for (int k = 0; k < 5; k++) begin
                fill(SL, 1'b0, 20 + k, ids[k], k == 0, 1'b0, 1'b0);
                exp_rd = ~exp_rd;
                chk(irq == exq[k][0], "R9 irq only on ID change", irq, exq[k]);
                chk(buf_ready == 1, "R9 ready still set", buf_ready, 1);
                do_ack();
            end
            cat_code = DC ^ 8'h01;
            for (int k = 0; k < 2; k++) begin
                fill(SL, 1'b0, 30 + k, 1, 1'b0, 1'b0, 1'b0);
                exp_rd = ~exp_rd;
                chk(irq == 1, "R10 category mismatch", irq, 1);
                do_ack();
            end
            cfg_dat_filt = 1'b0;
        end

        // R2: inactive modes
        for (int m = 0; m < 4; m++) begin
            if (m == 1) continue;
            @(negedge clk); cfg_mode = 2'(m);
            base = irq_cnt;
            for (int i = 0; i < 2 * LL; i++)
                sub(i[0], (i % 16) == 0, pbit(m, i), 1'b0);
            @(posedge clk); #1;
            chk(buf_ready == 0, "R2 no ready when off", buf_ready, 0);
            chk(irq_cnt == base, "R2 no irq when off", irq_cnt - base, 0);
            chk(rd_buf == exp_rd, "R2 rd_buf unchanged", rd_buf, exp_rd);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule